// File: doc/BRIEF.md
# Page-Buffered Serial Flash Command Slave

This block is the serial front end of a page-organised flash store with one SRAM staging page. A host selects it with an active-low chip select and clocks in commands on a serial data line. It answers on an output line that has its own enable, so an outside pad can release the line. The serial clock may idle low or high. Each frame carries an 8-bit command code, then a 24-bit address. Some commands add filler bytes before data moves. Raising chip select ends the frame.

Hosts use the staging page as a scratchpad. They write bytes into it, or read them back. They fill it from a stored page, or commit it to a stored page. A commit wipes the target page to all ones and then programs it from the staging page. While a fill or commit runs, the `ready` output is low for a fixed number of system clocks. During that time only status reads are served. The stored array is a small synthesizable model with a reduced page count, and each page holds 264 bytes.

All serial inputs pass through synchronisers into the system clock domain. The design acts on serial clock edges as the synchronisers see them.

Top module: `sflash_cmd_slave`

## Requirements
- R1: A frame is an 8-bit command code, then a 24-bit address, sent most significant bit first and sampled on rising serial clock edges. Address bits 23:18 are ignored. Bits 17:9 select the page, of which the model uses the low log2(PAGES) bits. Bits 8:0 give the starting byte.
- R2: Command 84h stores each following whole byte into the staging page, starting at the address byte and moving up one position per byte.
- R3: Command 54h sends one filler byte after the address. The staging page bytes then follow from the address byte, most significant bit first. Each bit is driven after a falling serial clock edge.
- R4: Command 52h sends four filler bytes after the address. Bytes of the selected stored page then follow from the address byte, in the same bit order as R3.
- R5: During reads and writes, the byte position steps from 263 back to 0. A starting byte above 263 is treated as 0.
- R6: Command 53h followed by chip select rising copies the selected stored page into the staging page.
- R7: Command 83h followed by chip select rising sets the selected stored page to all ones. It then programs the page from the staging page. Programming can only clear bits, and the final page equals the staging page whatever the page held before.
- R8: `ready` is 1 after reset. It goes low within a few clocks of the chip select rise that starts R6 or R7. It stays low for BUSY_CYCLES clocks and then returns high.
- R9: Command 57h returns a status byte repeatedly until chip select rises, including while busy. Bit 7 is ready, bits 5:3 are 001, and the other bits are 0. Bit 7 follows `ready` live.
- R10: While `ready` is low, any command code other than 57h is ignored: nothing is output and nothing is stored.
- R11: `spi_miso_en` is low while chip select is high, during command, address and filler bytes, and during write data.
- R12: Serial clock idle low (mode 0) and idle high (mode 3) work alike.
- R13: An unknown command code produces no output and changes no storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_en | output | 1 | Drive enable for spi_miso; low means released |
| ready | output | 1 | 1 when no fill or commit is running |

## Verification
A status read can overlap the end of a commit. The busy timer may expire in the same clock in which the status byte presents its top bit. The bench starts a commit and keeps chip select low through about ten status bytes, so the ready transition falls inside one of them. Each returned byte must be 08h or 88h. Once 88h appears, no later byte may return to 08h. The last byte must be 88h. A second overlap is a command issued during a commit. The bench judges it at the ports: no output, and staging page contents unchanged afterwards.

// File: rtl/sflash_pkg.sv
package sflash_pkg;

    localparam logic [7:0] OP_MAIN_RD = 8'h52;
    localparam logic [7:0] OP_XFER    = 8'h53;
    localparam logic [7:0] OP_BUF_RD  = 8'h54;
    localparam logic [7:0] OP_STATUS  = 8'h57;
    localparam logic [7:0] OP_PROG    = 8'h83;
    localparam logic [7:0] OP_BUF_WR  = 8'h84;

    localparam logic [2:0] DENSITY_CODE = 3'b001;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_DUMMY,
        PH_WR,
        PH_RD,
        PH_STAT,
        PH_HOLD,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        MV_IDLE,
        MV_COPY,
        MV_ERASE,
        MV_PROG
    } mv_stage_e;

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic sel,
    output logic sel_start,
    output logic sel_end,
    output logic mosi_s
);

    typedef struct packed {
        logic [SYNC:0]   sck;
        logic [SYNC:0]   cs;
        logic [SYNC-1:0] mo;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d     = q;
        d.sck = {q.sck[SYNC-1:0], sck};
        d.cs  = {q.cs[SYNC-1:0], cs_n};
        d.mo  = {q.mo[SYNC-2:0], mosi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sck <= '0;
            q.cs  <= '1;
            q.mo  <= '0;
        end else begin
            q <= d;
        end
    end

    assign sck_rise  =  q.sck[SYNC-1] & ~q.sck[SYNC];
    assign sck_fall  = ~q.sck[SYNC-1] &  q.sck[SYNC];
    assign sel       = ~q.cs[SYNC-1];
    assign sel_start = ~q.cs[SYNC-1] &  q.cs[SYNC];
    assign sel_end   =  q.cs[SYNC-1] & ~q.cs[SYNC];
    assign mosi_s    =  q.mo[SYNC-1];

endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
    parameter int CYCLES = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/page_mover.sv
module page_mover #(
    parameter int PAGES      = 8,
    parameter int PAGE_BYTES = 264
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_copy,
    input  logic                          start_prog,
    input  logic [$clog2(PAGES)-1:0]      page,
    input  logic [7:0]                    main_rd,
    input  logic [7:0]                    buf_rd,
    output logic                          active,
    output logic [$clog2(PAGE_BYTES)-1:0] idx,
    output logic [$clog2(PAGES)-1:0]      pg,
    output logic                          buf_we,
    output logic                          main_we,
    output logic [7:0]                    main_wdata
);
    import sflash_pkg::*;

    localparam int PW = $clog2(PAGES);
    localparam int IW = $clog2(PAGE_BYTES);
    localparam logic [IW-1:0] LAST_IDX = IW'(PAGE_BYTES - 1);

    typedef struct packed {
        mv_stage_e       stage;
        logic [IW-1:0]   idx;
        logic [PW-1:0]   pg;
    } mv_t;

    mv_t q, d;

    always_comb begin
        d = q;
        unique case (q.stage)
            MV_IDLE: begin
                d.idx = '0;
                d.pg  = page;
                if (start_copy)      d.stage = MV_COPY;
                else if (start_prog) d.stage = MV_ERASE;
            end
            default: begin
                if (q.idx == LAST_IDX) begin
                    d.idx   = '0;
                    d.stage = (q.stage == MV_ERASE) ? MV_PROG : MV_IDLE;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active     = (q.stage != MV_IDLE);
    assign idx        = q.idx;
    assign pg         = q.pg;
    assign buf_we     = (q.stage == MV_COPY);
    assign main_we    = (q.stage == MV_ERASE) || (q.stage == MV_PROG);
    // erase sets all ones; programming may only clear bits
    assign main_wdata = (q.stage == MV_ERASE) ? 8'hFF : (main_rd & buf_rd);

endmodule

// File: rtl/page_store.sv
module page_store #(
    parameter int PAGES      = 8,
    parameter int PAGE_BYTES = 264
) (
    input  logic                          clk,
    input  logic [$clog2(PAGES)-1:0]      host_pg,
    input  logic [$clog2(PAGE_BYTES)-1:0] host_idx,
    input  logic                          host_buf_we,
    input  logic [7:0]                    host_wdata,
    output logic [7:0]                    host_main_q,
    output logic [7:0]                    host_buf_q,
    input  logic [$clog2(PAGES)-1:0]      mv_pg,
    input  logic [$clog2(PAGE_BYTES)-1:0] mv_idx,
    input  logic                          mv_buf_we,
    input  logic                          mv_main_we,
    input  logic [7:0]                    mv_main_wdata,
    output logic [7:0]                    mv_main_q,
    output logic [7:0]                    mv_buf_q
);

    localparam int PW    = $clog2(PAGES);
    localparam int IW    = $clog2(PAGE_BYTES);
    localparam int DEPTH = PAGES * PAGE_BYTES;
    localparam int MW    = $clog2(DEPTH);

    logic [7:0] main_mem [DEPTH];
    logic [7:0] buf_mem  [PAGE_BYTES];

    function automatic logic [MW-1:0] flat(input logic [PW-1:0] p, input logic [IW-1:0] i);
        return MW'(p) * MW'(PAGE_BYTES) + MW'(i);
    endfunction

    always_ff @(posedge clk) begin
        if (mv_main_we) main_mem[flat(mv_pg, mv_idx)] <= mv_main_wdata;
        if (mv_buf_we)        buf_mem[mv_idx]   <= mv_main_q;
        else if (host_buf_we) buf_mem[host_idx] <= host_wdata;
    end

    assign host_main_q = main_mem[flat(host_pg, host_idx)];
    assign host_buf_q  = buf_mem[host_idx];
    assign mv_main_q   = main_mem[flat(mv_pg, mv_idx)];
    assign mv_buf_q    = buf_mem[mv_idx];

endmodule

// File: rtl/sflash_cmd_slave.sv
module sflash_cmd_slave #(
    parameter int PAGES       = 8,
    parameter int PAGE_BYTES  = 264,
    parameter int BUSY_CYCLES = 600,
    parameter int SYNC        = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_en,
    output logic ready
);
    import sflash_pkg::*;

    localparam int PW = $clog2(PAGES);
    localparam int IW = $clog2(PAGE_BYTES);
    localparam logic [8:0] LAST_BA = 9'(PAGE_BYTES - 1);

    typedef struct packed {
        phase_e      phase;
        logic [7:0]  op;
        logic [7:0]  sh;
        logic [2:0]  bitc;
        logic [2:0]  cnt;
        logic [PW:0] ahi;
        logic [PW-1:0] pg;
        logic [8:0]  ba;
        logic        sdo;
        logic        sdo_en;
    } cmd_t;

    cmd_t q, d;

    logic sck_rise, sck_fall, sel, sel_start, sel_end, mosi_s;
    logic busy, start_copy, start_prog, start_any;
    logic bw_en;
    logic [7:0] bw_data, host_main_q, host_buf_q, rd_byte, status, byte_in;
    logic mv_active, mv_buf_we, mv_main_we;
    logic [IW-1:0] mv_idx;
    logic [PW-1:0] mv_pg;
    logic [7:0] mv_main_wdata, mv_main_q, mv_buf_q;

    spi_edge_sync #(.SYNC(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .sel(sel),
        .sel_start(sel_start), .sel_end(sel_end), .mosi_s(mosi_s)
    );

    busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start_any), .busy(busy)
    );

    page_mover #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_mover (
        .clk(clk), .rst_n(rst_n), .start_copy(start_copy), .start_prog(start_prog),
        .page(q.pg), .main_rd(mv_main_q), .buf_rd(mv_buf_q), .active(mv_active),
        .idx(mv_idx), .pg(mv_pg), .buf_we(mv_buf_we), .main_we(mv_main_we),
        .main_wdata(mv_main_wdata)
    );

    page_store #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk(clk), .host_pg(q.pg), .host_idx(IW'(q.ba)), .host_buf_we(bw_en),
        .host_wdata(bw_data), .host_main_q(host_main_q), .host_buf_q(host_buf_q),
        .mv_pg(mv_pg), .mv_idx(mv_idx), .mv_buf_we(mv_buf_we), .mv_main_we(mv_main_we),
        .mv_main_wdata(mv_main_wdata), .mv_main_q(mv_main_q), .mv_buf_q(mv_buf_q)
    );

    function automatic logic [8:0] step_ba(input logic [8:0] ba);
        return (ba >= LAST_BA) ? 9'd0 : ba + 9'd1;
    endfunction

    assign status  = {~busy, 1'b0, DENSITY_CODE, 3'b000};
    assign byte_in = {q.sh[6:0], mosi_s};
    assign rd_byte = (q.phase == PH_STAT)   ? status      :
                     (q.op == OP_MAIN_RD)   ? host_main_q : host_buf_q;

    always_comb begin
        d          = q;
        start_copy = 1'b0;
        start_prog = 1'b0;
        bw_en      = 1'b0;
        bw_data    = byte_in;
        if (!sel) begin
            d.sdo_en = 1'b0;
            d.sdo    = 1'b0;
            d.phase  = PH_IDLE;
            if (sel_end && q.phase == PH_HOLD && !busy) begin
                start_copy = (q.op == OP_XFER);
                start_prog = (q.op == OP_PROG);
            end
        end else if (sel_start) begin
            d.phase = PH_OPC;
            d.bitc  = '0;
            d.cnt   = '0;
            d.sh    = '0;
        end else begin
            if (sck_fall && (q.phase == PH_RD || q.phase == PH_STAT)) begin
                d.sdo_en = 1'b1;
                d.sdo    = rd_byte[~q.bitc];
            end
            if (sck_rise) begin
                d.sh   = byte_in;
                d.bitc = q.bitc + 3'd1;
                if (q.bitc == 3'd7) begin
                    unique case (q.phase)
                        PH_OPC: begin
                            d.op  = byte_in;
                            d.cnt = '0;
                            if (busy && byte_in != OP_STATUS) begin
                                d.phase = PH_SKIP;
                            end else begin
                                unique case (byte_in)
                                    OP_STATUS: d.phase = PH_STAT;
                                    OP_MAIN_RD, OP_BUF_RD, OP_BUF_WR,
                                    OP_XFER, OP_PROG: d.phase = PH_ADDR;
                                    default: d.phase = PH_SKIP;
                                endcase
                            end
                        end
                        PH_ADDR: begin
                            d.ahi = (PW+1)'({q.ahi, byte_in});
                            d.cnt = q.cnt + 3'd1;
                            if (q.cnt == 3'd2) begin
                                d.pg = q.ahi[PW:1];
                                d.ba = ({q.ahi[0], byte_in} > LAST_BA) ? 9'd0
                                       : {q.ahi[0], byte_in};
                                unique case (q.op)
                                    OP_MAIN_RD: begin d.phase = PH_DUMMY; d.cnt = 3'd0; end
                                    OP_BUF_RD:  begin d.phase = PH_DUMMY; d.cnt = 3'd3; end
                                    OP_BUF_WR:  d.phase = PH_WR;
                                    default:    d.phase = PH_HOLD;
                                endcase
                            end
                        end
                        PH_DUMMY: begin
                            if (q.cnt == 3'd3) d.phase = PH_RD;
                            else               d.cnt   = q.cnt + 3'd1;
                        end
                        PH_WR: begin
                            bw_en = 1'b1;
                            d.ba  = step_ba(q.ba);
                        end
                        PH_RD: begin
                            d.ba = step_ba(q.ba);
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign start_any   = start_copy | start_prog;
    assign spi_miso    = q.sdo;
    assign spi_miso_en = q.sdo_en;
    assign ready       = ~busy;

endmodule

// File: rtl/sflash_cmd_slave_chk.sv
module sflash_cmd_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sel,
    input logic miso_en,
    input logic busy,
    input logic mv_active,
    input logic spi_buf_we,
    input logic main_we,
    input logic start_any,
    input logic ready
);

    // R11: a deselected slave releases its output on the next clock
    a_r11_release_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !miso_en);

    // R8: a started fill or commit pulls ready low at once
    a_r8_ready_drops_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_any |=> !ready);

    // R8: the copy engine finishes inside the busy window
    a_r8_engine_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mv_active |-> busy);

    // R10: no host write reaches the staging page while busy
    a_r10_no_host_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        spi_buf_we |-> !busy);

    // R7: the stored array changes only during a commit
    a_r7_array_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        main_we |-> busy);

endmodule

bind sflash_cmd_slave sflash_cmd_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .miso_en(spi_miso_en), .busy(busy),
    .mv_active(mv_active), .spi_buf_we(bw_en), .main_we(mv_main_we),
    .start_any(start_any), .ready(ready)
);

// File: tb/sflash_cmd_slave_bench.sv
`timescale 1ns/1ps
module sflash_cmd_slave_bench;

    localparam int BUSY = 600;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, miso_en, ready;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sflash_cmd_slave #(.BUSY_CYCLES(BUSY)) u_sflash_cmd_slave (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_en(miso_en), .ready(ready)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic spi_begin(input bit m3);
        sck = m3;
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic spi_end(input bit m3);
        if (!m3) sck = 1'b0;
        tick(HALF);
        cs_n = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx, output bit en);
        en = 0;
        rx = '0;
        for (int i = 7; i >= 0; i--) begin
            if (sck) sck = 1'b0;
            mosi = tx[i];
            tick(HALF);
            rx[i] = miso;
            if (miso_en) en = 1;
            sck = 1'b1;
            tick(HALF);
        end
    endtask

    task automatic send_hdr(input logic [7:0] op, input logic [8:0] pg, input logic [8:0] ba,
                            input logic [5:0] rsv, output bit en);
        logic [7:0] r;
        bit e0, e1, e2, e3;
        spi_byte(op, r, e0);
        spi_byte({rsv, pg[8:7]}, r, e1);
        spi_byte({pg[6:0], ba[8]}, r, e2);
        spi_byte(ba[7:0], r, e3);
        en = e0 | e1 | e2 | e3;
    endtask

    task automatic buf_write(input bit m3, input logic [8:0] ba, input logic [5:0] rsv,
                             input logic [31:0] data, input int n, output bit en);
        logic [7:0] r;
        bit e, eh;
        spi_begin(m3);
        send_hdr(8'h84, 9'd0, ba, rsv, eh);
        en = eh;
        for (int k = n - 1; k >= 0; k--) begin
            spi_byte(data[8*k +: 8], r, e);
            en |= e;
        end
        spi_end(m3);
    endtask

    task automatic read_cmd(input bit m3, input logic [7:0] op, input logic [8:0] pg,
                            input logic [8:0] ba, input int ndum, input int n,
                            output logic [31:0] data, output bit en_pre, output bit en_data);
        logic [7:0] r;
        bit e, eh;
        spi_begin(m3);
        send_hdr(op, pg, ba, 6'd0, eh);
        en_pre = eh;
        for (int k = 0; k < ndum; k++) begin
            spi_byte(8'h00, r, e);
            en_pre |= e;
        end
        data = '0;
        en_data = 0;
        for (int k = 0; k < n; k++) begin
            spi_byte(8'h00, r, e);
            data = {data[23:0], r};
            en_data |= e;
        end
        spi_end(m3);
    endtask

    task automatic start_cmd(input bit m3, input logic [7:0] op, input logic [8:0] pg);
        bit e;
        spi_begin(m3);
        send_hdr(op, pg, 9'd0, 6'd0, e);
        spi_end(m3);
    endtask

    task automatic wait_ready();
        int guard = 0;
        while (!ready && guard < 5000) begin
            tick(1);
            guard++;
        end
        chk("R8 ready returns", {31'd0, ready}, 32'd1);
    endtask

    task automatic t_reset();
        chk("R8 ready after reset", {31'd0, ready}, 32'd1);
        chk("R11 output released after reset", {31'd0, miso_en}, 32'd0);
    endtask

    task automatic t_buffer_rw();
        logic [31:0] d;
        bit ew, ep, ed;
        buf_write(0, 9'd5, 6'h3F, 32'hDEADBEEF, 4, ew);
        chk("R11 no output during write", {31'd0, ew}, 32'd0);
        read_cmd(0, 8'h54, 9'd0, 9'd5, 1, 4, d, ep, ed);
        chk("R2 R3 R1 buffer bytes back", d, 32'hDEADBEEF);
        chk("R11 quiet in header and filler", {31'd0, ep}, 32'd0);
        chk("R3 output enabled for data", {31'd0, ed}, 32'd1);
        read_cmd(0, 8'h54, 9'd0, 9'd6, 1, 2, d, ep, ed);
        chk("R3 read from mid address", d, 32'h0000ADBE);
    endtask

    task automatic t_wrap_mode3();
        logic [31:0] d;
        bit ew, ep, ed;
        buf_write(1, 9'd262, 6'd0, 32'hA0A1A2A3, 4, ew);
        read_cmd(1, 8'h54, 9'd0, 9'd262, 1, 4, d, ep, ed);
        chk("R5 R12 wrap read mode 3", d, 32'hA0A1A2A3);
        read_cmd(1, 8'h54, 9'd0, 9'd0, 1, 2, d, ep, ed);
        chk("R5 write wrapped to 0", d, 32'h0000A2A3);
        read_cmd(0, 8'h54, 9'd0, 9'd300, 1, 1, d, ep, ed);
        chk("R5 start above 263 reads byte 0", d, 32'h000000A2);
    endtask

    task automatic t_program_erase();
        logic [31:0] d;
        bit ew, ep, ed, e, low_seen;
        int cyc;
        buf_write(0, 9'd10, 6'd0, 32'h00000F55, 2, ew);
        spi_begin(0);
        send_hdr(8'h83, 9'd3, 9'd0, 6'd0, e);
        sck = 1'b0;
        tick(HALF);
        cs_n = 1'b1;
        cyc = 0;
        low_seen = 0;
        while (!ready || cyc < 10) begin
            tick(1);
            cyc++;
            if (cyc == 10 && !ready) low_seen = 1;
            if (cyc > 5000) break;
        end
        chk("R8 ready low after commit start", {31'd0, low_seen}, 32'd1);
        chk("R8 busy length", {31'd0, (cyc >= BUSY) && (cyc <= BUSY + 6)}, 32'd1);
        tick(HALF);
        buf_write(0, 9'd10, 6'd0, 32'h0000F0AA, 2, ew);
        start_cmd(0, 8'h83, 9'd3);
        wait_ready();
        read_cmd(0, 8'h52, 9'd3, 9'd10, 4, 2, d, ep, ed);
        chk("R7 R4 page equals buffer after erase", d, 32'h0000F0AA);
        chk("R4 R11 quiet over four fillers", {31'd0, ep}, 32'd0);
    endtask

    task automatic t_transfer();
        logic [31:0] d;
        bit ew, ep, ed;
        buf_write(0, 9'd10, 6'd0, 32'h00007777, 2, ew);
        start_cmd(1, 8'h53, 9'd3);
        chk("R8 ready low during fill", {31'd0, ready}, 32'd0);
        wait_ready();
        read_cmd(0, 8'h54, 9'd0, 9'd10, 1, 2, d, ep, ed);
        chk("R6 page copied into buffer", d, 32'h0000F0AA);
        read_cmd(1, 8'h52, 9'd3, 9'd11, 4, 1, d, ep, ed);
        chk("R4 R12 page read mode 3", d, 32'h000000AA);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] d;
        bit ew, ep, ed;
        buf_write(0, 9'd20, 6'd0, 32'h0000003C, 1, ew);
        start_cmd(0, 8'h83, 9'd5);
        buf_write(0, 9'd20, 6'd0, 32'h00000055, 1, ew);
        wait_ready();
        read_cmd(0, 8'h54, 9'd0, 9'd20, 1, 1, d, ep, ed);
        chk("R10 write during busy ignored", d, 32'h0000003C);
        start_cmd(0, 8'h83, 9'd5);
        read_cmd(0, 8'h54, 9'd0, 9'd20, 1, 1, d, ep, ed);
        chk("R10 read during busy silent", {31'd0, ep | ed}, 32'd0);
        wait_ready();
    endtask

    task automatic t_status_poll();
        logic [7:0] r;
        logic [7:0] first, last;
        bit e, seen_ready;
        int bad;
        spi_begin(0);
        spi_byte(8'h57, r, e);
        spi_byte(8'h00, r, e);
        spi_end(0);
        chk("R9 status when idle", {24'd0, r}, 32'h88);
        start_cmd(0, 8'h83, 9'd6);
        spi_begin(0);
        spi_byte(8'h57, r, e);
        bad = 0;
        seen_ready = 0;
        first = 8'h00;
        last = 8'h00;
        for (int k = 0; k < 10; k++) begin
            spi_byte(8'h00, r, e);
            if (k == 0) first = r;
            last = r;
            if (r != 8'h08 && r != 8'h88) bad++;
            if (r == 8'h88) seen_ready = 1;
            else if (seen_ready) bad++;
        end
        spi_end(0);
        chk("R9 first status busy", {24'd0, first}, 32'h08);
        chk("R9 status sequence well formed", bad, 32'd0);
        chk("R9 status shows ready at end", {24'd0, last}, 32'h88);
        wait_ready();
    endtask

    task automatic t_bad_opcode();
        logic [31:0] d;
        logic [7:0] r;
        bit ew, ep, ed, eh, e1, e2;
        buf_write(0, 9'd30, 6'd0, 32'h0000005A, 1, ew);
        spi_begin(0);
        send_hdr(8'hA5, 9'd0, 9'd30, 6'd0, eh);
        spi_byte(8'h11, r, e1);
        spi_byte(8'h11, r, e2);
        spi_end(0);
        chk("R13 unknown code silent", {31'd0, eh | e1 | e2}, 32'd0);
        read_cmd(0, 8'h54, 9'd0, 9'd30, 1, 1, d, ep, ed);
        chk("R13 unknown code stores nothing", d, 32'h0000005A);
        chk("R11 released after frames", {31'd0, miso_en}, 32'd0);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_buffer_rw();
        t_wrap_mode3();
        t_program_erase();
        t_transfer();
        t_busy_ignore();
        t_status_poll();
        t_bad_opcode();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule